// File: doc/BRIEF.md
# Set-Associative Victim Way Selector

This block decides which way of a set-associative cache is refilled when a lookup misses. The cache presents a set index together with one of three strobes. A hit strobe reports which way just hit. A victim request asks for a way to refill. A flush strobe returns the replacement bookkeeping of every set to its initial order. A two-bit policy code picks the replacement algorithm at run time: random with lowest-first filling of ways not yet used, least recently used, or least frequently used.

The answer comes back on `victim_way` together with a `victim_valid` pulse, one clock edge after the request. Each set holds a recency order and a pool of never-allocated ways. Each line holds an 8-bit saturating use counter. Tag compare, line data and memory traffic belong to the surrounding cache and are not part of this block.

Top module: `way_victim_sel`

## Requirements
- R1: `policy` 2 selects least recently used and 3 selects least frequently used. Codes 1 and 0 select random. A strobe changes only the state of the policy active in its cycle and only the state of the addressed set.
- R2: Under random, while the addressed set still has ways that have not been allocated since reset or the last flush, the victim is the lowest-numbered such way, and that way leaves the pool. Hits do not change the pool.
- R3: Under random with an empty pool, the victim is the low log2(WAYS) bits of an 8-bit register. The register is 0xA5 in reset and shifts left on every clock, taking as its new bit 0 the XOR of bits 7, 5, 4 and 3. The request samples the register value held just before its edge.
- R4: Under least recently used, each set keeps an order of its ways, initially 0..WAYS-1 from least to most recent. A hit moves the hit way to the most-recent end. A request returns the least-recent way and moves it to the most-recent end.
- R5: Under least frequently used, the victim is the way of the set with the smallest use counter, ties going to the lowest way number. The counter increments on every hit to that line and when the line is returned as a victim.
- R6: Use counters are 8 bits wide and stay at 255 instead of wrapping to 0.
- R7: `flush` resets every set's order and pool to ways 0..WAYS-1 and leaves the use counters untouched. A request in a flush cycle is dropped and `victim_valid` stays low.
- R8: When `victim_req` and `hit_valid` are high in the same cycle, only the request is processed.
- R9: `victim_valid` rises one edge after an accepted request and lasts one cycle. `victim_way` holds its value until the next accepted request. Both outputs are 0 in reset.
- R10: With a single way, the returned victim is always way 0 under every policy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| set_idx | input | SET_W | Set addressed by the strobes of this cycle |
| policy | input | 2 | Replacement algorithm code |
| hit_valid | input | 1 | A lookup hit way `hit_way` |
| hit_way | input | WAY_W | Way that hit |
| victim_req | input | 1 | Ask for a way to refill |
| flush | input | 1 | Reset orders and pools of all sets |
| victim_valid | output | 1 | Pulse: `victim_way` answers the request of the previous cycle |
| victim_way | output | WAY_W | Chosen way |

## Verification
The victim answer is due at the first rising edge after the request cycle, so each stimulus is applied at a falling edge and the outputs are read 1 ns after the following rising edge, before any new stimulus arrives. Hits and flushes have no output of their own. Their effect is checked through the victim returned by the next request. The random register is mirrored in the bench from the stated polynomial, and the bench takes its expected value at the falling edge just before the sampling edge. A saturation case drives exactly enough hits that a wrapping counter would land at 0, which makes wrap and saturation produce different victims.

// File: rtl/wvs_pkg.sv
package wvs_pkg;

  localparam logic [1:0] POL_RAND = 2'd1;
  localparam logic [1:0] POL_LRU  = 2'd2;
  localparam logic [1:0] POL_LFU  = 2'd3;

  localparam int         RNG_W    = 8;
  localparam logic [RNG_W-1:0] RNG_SEED = 8'hA5;

  // One step of the shift register: taps 8,6,5,4.
  function automatic logic [RNG_W-1:0] rng_step(input logic [RNG_W-1:0] s);
    return {s[RNG_W-2:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction

endpackage

// File: rtl/wvs_rng.sv
module wvs_rng
  import wvs_pkg::*;
#(
  parameter int OUT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [OUT_W-1:0] rnd
);

  logic [RNG_W-1:0] state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= RNG_SEED;
    else        state_q <= rng_step(state_q);
  end

  assign rnd = state_q[OUT_W-1:0];

  // R3: the register never locks up at zero
  a_r3_rng_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);

endmodule

// File: rtl/wvs_lru_table.sv
module wvs_lru_table #(
  parameter int SETS  = 4,
  parameter int WAYS  = 4,
  parameter int SET_W = 2,
  parameter int WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             upd_en,
  input  logic [SET_W-1:0] set_idx,
  input  logic [WAY_W-1:0] touch_way,
  output logic [WAY_W-1:0] lru_way
);

  localparam int ROW_W = WAYS * WAY_W;

  // Slot 0 is least recent, slot WAYS-1 most recent.
  logic [ROW_W-1:0] order_q [SETS];

  function automatic logic [ROW_W-1:0] ascending_row();
    logic [ROW_W-1:0] r;
    for (int i = 0; i < WAYS; i++) r[i*WAY_W +: WAY_W] = WAY_W'(i);
    return r;
  endfunction

  function automatic logic [ROW_W-1:0] move_back(input logic [ROW_W-1:0] row,
                                                  input logic [WAY_W-1:0] w);
    logic [ROW_W-1:0] r;
    logic             seen;
    seen = 1'b0;
    r    = row;
    for (int i = 0; i < WAYS - 1; i++) begin
      if (row[i*WAY_W +: WAY_W] == w) seen = 1'b1;
      r[i*WAY_W +: WAY_W] = seen ? row[(i+1)*WAY_W +: WAY_W] : row[i*WAY_W +: WAY_W];
    end
    r[(WAYS-1)*WAY_W +: WAY_W] = w;
    return r;
  endfunction

  function automatic logic is_perm(input logic [ROW_W-1:0] row);
    logic ok;
    int   n;
    ok = 1'b1;
    for (int w = 0; w < WAYS; w++) begin
      n = 0;
      for (int i = 0; i < WAYS; i++)
        if (row[i*WAY_W +: WAY_W] == WAY_W'(w)) n++;
      if (n != 1) ok = 1'b0;
    end
    return ok;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) order_q[s] <= ascending_row();
    end else if (flush) begin
      for (int s = 0; s < SETS; s++) order_q[s] <= ascending_row();
    end else if (upd_en) begin
      order_q[set_idx] <= move_back(order_q[set_idx], touch_way);
    end
  end

  assign lru_way = order_q[set_idx][WAY_W-1:0];

  // R4: the order of the addressed set is always a permutation of the ways
  a_r4_order_perm: assert property (@(posedge clk) disable iff (!rst_n)
    is_perm(order_q[set_idx]));

endmodule

// File: rtl/wvs_lfu_table.sv
module wvs_lfu_table #(
  parameter int SETS  = 4,
  parameter int WAYS  = 4,
  parameter int SET_W = 2,
  parameter int WAY_W = 2,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bump_en,
  input  logic [SET_W-1:0] set_idx,
  input  logic [WAY_W-1:0] bump_way,
  output logic [WAY_W-1:0] min_way
);

  localparam int LINES = SETS * WAYS;
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q [LINES];
  logic [IDX_W-1:0] bump_idx;
  logic [IDX_W-1:0] bump_idx_q;
  logic [CNT_W-1:0] best_cnt;

  function automatic logic [IDX_W-1:0] slot(input logic [SET_W-1:0] s, input int w);
    return IDX_W'(int'(s) * WAYS + w);
  endfunction

  // Smallest counter of the set; strict compare keeps the lowest way on ties.
  always_comb begin
    min_way  = '0;
    best_cnt = cnt_q[slot(set_idx, 0)];
    for (int w = 1; w < WAYS; w++) begin
      if (cnt_q[slot(set_idx, w)] < best_cnt) begin
        best_cnt = cnt_q[slot(set_idx, w)];
        min_way  = WAY_W'(w);
      end
    end
  end

  assign bump_idx = slot(set_idx, int'(bump_way));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) cnt_q[i] <= '0;
      bump_idx_q <= '0;
    end else begin
      bump_idx_q <= bump_idx;
      if (bump_en && cnt_q[bump_idx] != CNT_MAX)
        cnt_q[bump_idx] <= cnt_q[bump_idx] + 1'b1;
    end
  end

  // R6: a bumped counter is never zero afterwards, so it did not wrap
  a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    bump_en |=> cnt_q[bump_idx_q] != '0);

endmodule

// File: rtl/way_victim_sel.sv
module way_victim_sel
  import wvs_pkg::*;
#(
  parameter int SETS  = 4,
  parameter int WAYS  = 4,
  parameter int CNT_W = 8,
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] set_idx,
  input  logic [1:0]       policy,
  input  logic             hit_valid,
  input  logic [WAY_W-1:0] hit_way,
  input  logic             victim_req,
  input  logic             flush,
  output logic             victim_valid,
  output logic [WAY_W-1:0] victim_way
);

  // Named events for the assertions
  logic req_fire, hit_fire;
  logic is_lru, is_lfu, is_rand;

  logic [WAY_W-1:0] lru_way, lfu_way, rand_way, hit_way_eff;
  logic [WAY_W-1:0] lru_touch, lfu_touch, choice;
  logic             lru_upd, lfu_upd;

  logic [WAYS-1:0] fresh_q [SETS];
  logic [WAYS-1:0] fresh_row;

  function automatic logic [WAY_W-1:0] first_free(input logic [WAYS-1:0] v);
    logic [WAY_W-1:0] r;
    r = '0;
    for (int i = WAYS - 1; i >= 0; i--) if (v[i]) r = WAY_W'(i);
    return r;
  endfunction

  assign req_fire = victim_req && !flush;
  assign hit_fire = hit_valid && !victim_req && !flush;
  assign is_lru   = (policy == POL_LRU);
  assign is_lfu   = (policy == POL_LFU);
  assign is_rand  = !is_lru && !is_lfu;

  assign fresh_row = fresh_q[set_idx];

  generate
    if (WAYS == 1) begin : g_one_way
      assign rand_way    = '0;
      assign hit_way_eff = '0;
    end else begin : g_many_way
      logic [WAY_W-1:0] rnd;
      wvs_rng #(.OUT_W(WAY_W)) rng_i (.clk(clk), .rst_n(rst_n), .rnd(rnd));
      assign rand_way    = (|fresh_row) ? first_free(fresh_row) : rnd;
      assign hit_way_eff = hit_way;
    end
  endgenerate

  assign lru_upd   = is_lru && (req_fire || hit_fire);
  assign lru_touch = req_fire ? lru_way : hit_way_eff;
  assign lfu_upd   = is_lfu && (req_fire || hit_fire);
  assign lfu_touch = req_fire ? lfu_way : hit_way_eff;

  wvs_lru_table #(.SETS(SETS), .WAYS(WAYS), .SET_W(SET_W), .WAY_W(WAY_W)) lru_i (
    .clk(clk), .rst_n(rst_n), .flush(flush), .upd_en(lru_upd),
    .set_idx(set_idx), .touch_way(lru_touch), .lru_way(lru_way)
  );

  wvs_lfu_table #(.SETS(SETS), .WAYS(WAYS), .SET_W(SET_W), .WAY_W(WAY_W),
                  .CNT_W(CNT_W)) lfu_i (
    .clk(clk), .rst_n(rst_n), .bump_en(lfu_upd), .set_idx(set_idx),
    .bump_way(lfu_touch), .min_way(lfu_way)
  );

  always_comb begin
    if (is_lru)      choice = lru_way;
    else if (is_lfu) choice = lfu_way;
    else             choice = rand_way;
  end

  // Pool of ways not yet allocated under random
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) fresh_q[s] <= '1;
    end else if (flush) begin
      for (int s = 0; s < SETS; s++) fresh_q[s] <= '1;
    end else if (req_fire && is_rand && (|fresh_row)) begin
      fresh_q[set_idx][rand_way] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      victim_valid <= 1'b0;
      victim_way   <= '0;
    end else begin
      victim_valid <= req_fire;
      if (req_fire) victim_way <= choice;
    end
  end

  // R9: an accepted request is answered on the next edge
  a_r9_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    (victim_req && !flush) |=> victim_valid);

  // R9: the answer is held while no request arrives
  a_r9_way_held: assert property (@(posedge clk) disable iff (!rst_n)
    !victim_req |=> $stable(victim_way));

  // R7: a flush cycle produces no answer
  a_r7_flush_drops_req: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !victim_valid);

  generate
    if (WAYS == 1) begin : g_chk_one
      // R10: single way always answers way 0
      a_r10_single_way: assert property (@(posedge clk) disable iff (!rst_n)
        victim_valid |-> victim_way == '0);
    end
  endgenerate

endmodule

// File: tb/way_victim_sel_tb_top.sv
module way_victim_sel_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] set_idx, policy, hit_way;
  logic       hit_valid, victim_req, flush;
  logic       victim_valid;
  logic [1:0] victim_way;

  // single-way instance
  logic       o_set, o_hit_way, o_hit_valid, o_req;
  logic [1:0] o_policy;
  logic       o_valid, o_way;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] model_rng;
  logic [1:0] rng_exp;

  always #2 clk = ~clk;

  way_victim_sel dut_i (
    .clk(clk), .rst_n(rst_n), .set_idx(set_idx), .policy(policy),
    .hit_valid(hit_valid), .hit_way(hit_way), .victim_req(victim_req),
    .flush(flush), .victim_valid(victim_valid), .victim_way(victim_way)
  );

  way_victim_sel #(.SETS(2), .WAYS(1)) dut_one_i (
    .clk(clk), .rst_n(rst_n), .set_idx(o_set), .policy(o_policy),
    .hit_valid(o_hit_valid), .hit_way(o_hit_way), .victim_req(o_req),
    .flush(1'b0), .victim_valid(o_valid), .victim_way(o_way)
  );

  // R3 mirror: seed 0xA5, shift left, new bit = b7^b5^b4^b3
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_rng <= 8'hA5;
    else        model_rng <= {model_rng[6:0],
                              model_rng[7] ^ model_rng[5] ^ model_rng[4] ^ model_rng[3]};
  end

  // fields: req[13:10] op[9:8] (0 hit,1 request) set[7:6] way[5:4] pol[3:2] exp[1:0]
  localparam int NV = 23;
  localparam logic [13:0] VEC [NV] = '{
    {4'd4, 2'd1, 2'd1, 2'd0, 2'd2, 2'd0},  // R4 LRU first victim
    {4'd4, 2'd1, 2'd1, 2'd0, 2'd2, 2'd1},  // R4
    {4'd4, 2'd0, 2'd1, 2'd2, 2'd2, 2'd0},  // R4 hit way 2
    {4'd4, 2'd1, 2'd1, 2'd0, 2'd2, 2'd3},  // R4
    {4'd4, 2'd0, 2'd1, 2'd0, 2'd2, 2'd0},  // R4 hit 0
    {4'd4, 2'd0, 2'd1, 2'd1, 2'd2, 2'd0},  // R4 hit 1
    {4'd4, 2'd1, 2'd1, 2'd0, 2'd2, 2'd2},  // R4
    {4'd4, 2'd1, 2'd2, 2'd0, 2'd2, 2'd0},  // R4 other set untouched
    {4'd5, 2'd1, 2'd3, 2'd0, 2'd3, 2'd0},  // R5 all zero -> way 0
    {4'd5, 2'd1, 2'd3, 2'd0, 2'd3, 2'd1},  // R5
    {4'd5, 2'd0, 2'd3, 2'd2, 2'd3, 2'd0},  // R5 hit bumps way 2
    {4'd5, 2'd1, 2'd3, 2'd0, 2'd3, 2'd3},  // R5
    {4'd5, 2'd1, 2'd3, 2'd0, 2'd3, 2'd0},  // R5 tie -> lowest
    {4'd5, 2'd0, 2'd3, 2'd1, 2'd3, 2'd0},  // R5 hit bumps way 1
    {4'd5, 2'd1, 2'd3, 2'd0, 2'd3, 2'd2},  // R5
    {4'd5, 2'd1, 2'd3, 2'd0, 2'd3, 2'd3},  // R5
    {4'd2, 2'd1, 2'd0, 2'd0, 2'd1, 2'd0},  // R2 pool lowest first
    {4'd2, 2'd1, 2'd0, 2'd0, 2'd1, 2'd1},  // R2
    {4'd1, 2'd0, 2'd0, 2'd3, 2'd1, 2'd0},  // R1 hit leaves pool alone
    {4'd2, 2'd1, 2'd0, 2'd0, 2'd1, 2'd2},  // R2
    {4'd2, 2'd1, 2'd0, 2'd0, 2'd1, 2'd3},  // R2 last fresh way
    {4'd1, 2'd1, 2'd2, 2'd0, 2'd0, 2'd0},  // R1 code 0 acts as random
    {4'd1, 2'd1, 2'd2, 2'd0, 2'd0, 2'd1}   // R1
  };

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic hv, input logic [1:0] hw, input logic vr,
                      input logic fl, input logic [1:0] s, input logic [1:0] pol);
    @(negedge clk);
    hit_valid = hv; hit_way = hw; victim_req = vr; flush = fl;
    set_idx = s; policy = pol;
    rng_exp = model_rng[1:0];
    @(posedge clk);
    #1;
    hit_valid = 1'b0; victim_req = 1'b0; flush = 1'b0;
  endtask

  task automatic expect_victim(input string tag, input int exp);
    check({tag, " valid"}, int'(victim_valid), 1);
    check({tag, " way"}, int'(victim_way), exp);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    set_idx = '0; policy = 2'd1; hit_way = '0;
    hit_valid = 1'b0; victim_req = 1'b0; flush = 1'b0;
    o_set = 1'b0; o_hit_way = 1'b0; o_hit_valid = 1'b0; o_req = 1'b0; o_policy = 2'd1;
    repeat (3) @(posedge clk);
    #1;
    // R9 reset values
    check("R9 reset valid", int'(victim_valid), 0);
    check("R9 reset way", int'(victim_way), 0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [13:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d vec%0d", v[13:10], i);
      step(v[9:8] == 2'd0, v[5:4], v[9:8] == 2'd1, 1'b0, v[7:6], v[3:2]);
      if (v[9:8] == 2'd1) expect_victim(tag, int'(v[1:0]));
      else check({tag, " R9 no answer on hit"}, int'(victim_valid), 0);
    end

    // R3: pool of set 0 is empty, victims follow the shift register
    for (int k = 0; k < 6; k++) begin
      step(1'b0, 2'd0, 1'b1, 1'b0, 2'd0, 2'd1);
      expect_victim($sformatf("R3 rnd%0d", k), int'(rng_exp));
    end
    // R9: valid is a single pulse and the way is held
    begin
      logic [1:0] held;
      held = victim_way;
      step(1'b1, 2'd2, 1'b0, 1'b0, 2'd0, 2'd1);
      check("R9 pulse ends", int'(victim_valid), 0);
      check("R9 way held", int'(victim_way), int'(held));
    end

    // R7: flush resets order and pool but keeps counters
    step(1'b1, 2'd0, 1'b0, 1'b0, 2'd3, 2'd3);
    step(1'b1, 2'd1, 1'b0, 1'b0, 2'd3, 2'd3);    // counters now 3,3,2,2
    step(1'b0, 2'd0, 1'b0, 1'b1, 2'd0, 2'd1);
    check("R7 flush no answer", int'(victim_valid), 0);
    step(1'b0, 2'd0, 1'b1, 1'b0, 2'd1, 2'd2);
    expect_victim("R7 order restored", 0);
    step(1'b0, 2'd0, 1'b1, 1'b0, 2'd0, 2'd1);
    expect_victim("R7 pool restored", 0);
    step(1'b0, 2'd0, 1'b1, 1'b0, 2'd3, 2'd3);
    expect_victim("R7 counters kept", 2);       // counters now 3,3,3,2

    // R8: request wins over a same-cycle hit (set 2 order 0,1,2,3)
    step(1'b1, 2'd1, 1'b1, 1'b0, 2'd2, 2'd2);
    expect_victim("R8 request served", 0);
    step(1'b0, 2'd0, 1'b1, 1'b0, 2'd2, 2'd2);
    expect_victim("R8 hit ignored", 1);

    // R7: request in a flush cycle is dropped
    step(1'b0, 2'd0, 1'b1, 1'b1, 2'd1, 2'd2);
    check("R7 flush drops request", int'(victim_valid), 0);
    step(1'b0, 2'd0, 1'b1, 1'b0, 2'd1, 2'd2);
    expect_victim("R7 flush applied", 0);

    // R6: 254 hits on way 3 (count 2): wrapping would give 0, saturating 255
    for (int k = 0; k < 254; k++) step(1'b1, 2'd3, 1'b0, 1'b0, 2'd3, 2'd3);
    step(1'b0, 2'd0, 1'b1, 1'b0, 2'd3, 2'd3);
    expect_victim("R6 saturated", 0);

    // R10: single way under each policy
    for (int p = 1; p <= 3; p++) begin
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        o_policy = 2'(p); o_set = k[0]; o_hit_valid = 1'b1; o_hit_way = 1'b1;
        @(negedge clk);
        o_hit_valid = 1'b0; o_req = 1'b1;
        @(posedge clk);
        #1;
        o_req = 1'b0;
        check($sformatf("R10 valid p%0d", p), int'(o_valid), 1);
        check($sformatf("R10 way p%0d", p), int'(o_way), 0);
      end
    end

    finish_run();
  end

endmodule